// File: doc/BRIEF.md
# Instruction Trace Exception Generator

This block decides, once per completed instruction, whether a trace exception has to be raised. It reads a two-bit trace-mode field from the status register. Each time an instruction retires it looks at four things: the kind of instruction, whether the instruction wrote the status register, the program counter it left behind, and the address that would have followed it in sequence. From these it produces a single-cycle trace request for the exception unit.

Two kinds of tracing are supported. The first traces every instruction. The second traces only on a change of flow, which covers a status-register write or a program counter that is not the next sequential address.

Coprocessor general instructions get special handling in change-of-flow mode. The coprocessor interface can report a transfer-status-and-scan-PC primitive that has its destination-relative flag set. In that mode a coprocessor general instruction is traced only when this indication arrived while the instruction was executing. Coprocessor save, restore and conditional instructions have no special case and are judged like any other instruction.

A request that cannot go out because the exception unit is busy is held pending. It is issued as soon as the unit is free.

Top module: `trc_gen_top`

## Requirements
- R1: A synchronous active-high reset drives `trc_req` low and clears both the pending request and the latched scan indication. After reset, a coprocessor general instruction retiring in change-of-flow mode without a new scan indication produces no request.
- R2: With `trc_mode` = 2'b10 (per-instruction), every retire strobe of any kind produces `trc_req` high in the cycle right after the strobe, provided `exc_busy` is low in the strobe cycle. There is never a request before the strobe.
- R3: With `trc_mode` = 2'b00 or 2'b11, no retire ever produces a request.
- R4: With `trc_mode` = 2'b01 (change of flow), a retire of any kind other than coprocessor general (kind code 1) with `ret_sr_wr` high produces a request.
- R5: In change-of-flow mode, a non-coprocessor-general retire produces a request when `ret_pc` differs from `ret_next`. It produces none when the two are equal and `ret_sr_wr` is low. Kind codes 0 (plain), 2 (coprocessor save), 3 (coprocessor restore) and 4 (coprocessor conditional) all follow this rule.
- R6: In change-of-flow mode, a coprocessor general retire (kind code 1) produces a request exactly when `cp_dr_scan` was high in some cycle after the previous retire strobe, up to and including the strobe cycle. `ret_sr_wr`, `ret_pc` and `ret_next` have no effect on this kind.
- R7: The latched scan indication is consumed by every retire strobe. A scan that arrives during one instruction never causes a trace for a later instruction.
- R8: When a request is due while `exc_busy` is high, it is held. `trc_req` pulses for one cycle in the cycle after the first cycle in which `exc_busy` is low.
- R9: Any further traced retires that occur while a request is held are merged into it, so that one pulse is emitted for all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_mode | input | 2 | Trace-mode field from the status register: 01 change of flow, 10 every instruction, others off |
| ret_vld | input | 1 | Instruction retire strobe |
| ret_kind | input | 3 | Retiring instruction kind: 0 plain, 1 coprocessor general, 2 save, 3 restore, 4 conditional |
| ret_sr_wr | input | 1 | Retiring instruction wrote the status register |
| ret_pc | input | AW | Program counter after the instruction |
| ret_next | input | AW | Sequential next-instruction address |
| cp_dr_scan | input | 1 | Coprocessor issued a transfer-status-and-scan-PC primitive with destination-relative flag set |
| exc_busy | input | 1 | Exception unit cannot accept a request this cycle |
| trc_req | output | 1 | One-cycle trace request to the exception unit |

## Verification
The assertions assume that `trc_mode` is sampled in the retire cycle and that it describes the instruction retiring in that cycle. They also assume `cp_dr_scan` belongs to whichever instruction retires next. The stimulus follows both assumptions. It changes the mode only between instructions and places each scan pulse either in the cycle just before a retire or in the retire cycle itself, which covers both edges of the latch window. Busy windows are opened and closed only on clock boundaries, and while one is open the bench retires instructions only to exercise merging.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    TM_OFF0 = 2'b00,
    TM_FLOW = 2'b01,
    TM_EACH = 2'b10,
    TM_OFF3 = 2'b11
  } trc_mode_e;

  localparam int KIND_W = 3;

  localparam logic [KIND_W-1:0] K_PLAIN = 3'd0;
  localparam logic [KIND_W-1:0] K_CPGEN = 3'd1;
  localparam logic [KIND_W-1:0] K_CPSAV = 3'd2;
  localparam logic [KIND_W-1:0] K_CPRST = 3'd3;
  localparam logic [KIND_W-1:0] K_CPCND = 3'd4;

  // Per-instruction trace decision; kept pure so it can be restated elsewhere.
  function automatic logic flow_changed(input logic sr_wr, input logic pc_jump);
    return sr_wr | pc_jump;
  endfunction

  function automatic logic trace_due(
    input trc_mode_e       mode,
    input logic [KIND_W-1:0] kind,
    input logic            sr_wr,
    input logic            pc_jump,
    input logic            dr_seen
  );
    logic r;
    unique case (mode)
      TM_EACH: r = 1'b1;
      TM_FLOW: r = (kind == K_CPGEN) ? dr_seen : flow_changed(sr_wr, pc_jump);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/trc_scan_latch.sv
module trc_scan_latch (
  input  logic clk,
  input  logic rst,
  input  logic scan_in,
  input  logic retire,
  output logic seen
);

  logic held_q;

  // The indication for the retiring instruction includes a scan in the same cycle.
  assign seen = held_q | scan_in;

  always_ff @(posedge clk) begin
    if (rst)         held_q <= 1'b0;
    else if (retire) held_q <= 1'b0;
    else if (scan_in) held_q <= 1'b1;
  end

  AST_SCAN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    retire |=> !held_q); // R7

  AST_SCAN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (held_q && !retire) |=> held_q); // R6

endmodule

// File: rtl/trc_decide.sv
module trc_decide #(
  parameter int AW = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 mode,
  input  logic                       retire,
  input  logic [trc_pkg::KIND_W-1:0] kind,
  input  logic                       sr_wr,
  input  logic [AW-1:0]              pc,
  input  logic [AW-1:0]              next_pc,
  input  logic                       dr_seen,
  output logic                       hit
);
  import trc_pkg::*;

  trc_mode_e mode_e;
  logic      pc_jump;

  assign mode_e  = trc_mode_e'(mode);
  assign pc_jump = (pc != next_pc);
  assign hit     = retire & trace_due(mode_e, kind, sr_wr, pc_jump, dr_seen);

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |-> !hit); // R3

  AST_EACH_HITS: assert property (@(posedge clk) disable iff (rst)
    (retire && mode == 2'b10) |-> hit); // R2

  AST_FLOW_SR: assert property (@(posedge clk) disable iff (rst)
    (retire && mode == 2'b01 && kind != K_CPGEN && sr_wr) |-> hit); // R4

  AST_FLOW_SEQ: assert property (@(posedge clk) disable iff (rst)
    (retire && mode == 2'b01 && kind != K_CPGEN && !sr_wr && pc == next_pc) |-> !hit); // R5

  AST_CPGEN_DR: assert property (@(posedge clk) disable iff (rst)
    (retire && mode == 2'b01 && kind == K_CPGEN) |-> (hit == dr_seen)); // R6

endmodule

// File: rtl/trc_req_hold.sv
module trc_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic busy,
  output logic pend,
  output logic req
);

  logic want;

  assign want = hit | pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      req  <= 1'b0;
    end else begin
      req <= want & ~busy;
      if (!busy) pend <= 1'b0;
      else if (want) pend <= 1'b1;
    end
  end

  AST_REQ_CAUSED: assert property (@(posedge clk) disable iff (rst)
    req |-> ($past(hit || pend) && !$past(busy))); // R8

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend && busy) |=> (pend && !req)); // R8

  AST_PEND_ONCE: assert property (@(posedge clk) disable iff (rst)
    (pend && !busy) |=> (req && !pend)); // R9

endmodule

// File: rtl/trc_gen_top.sv
module trc_gen_top #(
  parameter int AW = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 trc_mode,
  input  logic                       ret_vld,
  input  logic [2:0]                 ret_kind,
  input  logic                       ret_sr_wr,
  input  logic [AW-1:0]              ret_pc,
  input  logic [AW-1:0]              ret_next,
  input  logic                       cp_dr_scan,
  input  logic                       exc_busy,
  output logic                       trc_req
);

  logic dr_seen;
  logic hit_now;
  logic req_pend;

  trc_scan_latch u_scan (
    .clk    (clk),
    .rst    (rst),
    .scan_in(cp_dr_scan),
    .retire (ret_vld),
    .seen   (dr_seen)
  );

  trc_decide #(.AW(AW)) u_decide (
    .clk    (clk),
    .rst    (rst),
    .mode   (trc_mode),
    .retire (ret_vld),
    .kind   (ret_kind),
    .sr_wr  (ret_sr_wr),
    .pc     (ret_pc),
    .next_pc(ret_next),
    .dr_seen(dr_seen),
    .hit    (hit_now)
  );

  trc_req_hold u_hold (
    .clk (clk),
    .rst (rst),
    .hit (hit_now),
    .busy(exc_busy),
    .pend(req_pend),
    .req (trc_req)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !trc_req); // R1

  AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    (trc_req && !$past(req_pend)) |-> $past(ret_vld)); // R2

endmodule

// File: tb/test_trc_gen_top.sv
module test_trc_gen_top;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    trc_mode;
  logic          ret_vld;
  logic [2:0]    ret_kind;
  logic          ret_sr_wr;
  logic [AW-1:0] ret_pc;
  logic [AW-1:0] ret_next;
  logic          cp_dr_scan;
  logic          exc_busy;
  logic          trc_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  trc_gen_top #(.AW(AW)) i_trc_gen_top (
    .clk(clk), .rst(rst), .trc_mode(trc_mode), .ret_vld(ret_vld),
    .ret_kind(ret_kind), .ret_sr_wr(ret_sr_wr), .ret_pc(ret_pc),
    .ret_next(ret_next), .cp_dr_scan(cp_dr_scan), .exc_busy(exc_busy),
    .trc_req(trc_req)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: trc_req actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    ret_vld = 1'b0; cp_dr_scan = 1'b0; ret_sr_wr = 1'b0;
    ret_kind = 3'd0; ret_pc = 16'h0100; ret_next = 16'h0100;
  endtask

  // Expected decision, worked out from the requirement text.
  function automatic logic model(input int m, input int k, input int sr,
                                 input int jmp, input int dr);
    if (m == 2) return 1'b1;
    if (m != 1) return 1'b0;
    if (k == 1) return dr != 0;
    return (sr != 0) || (jmp != 0);
  endfunction

  task automatic retire(input int m, input int k, input int sr, input int jmp,
                        input logic scan_same);
    trc_mode = 2'(m); ret_vld = 1'b1; ret_kind = 3'(k);
    ret_sr_wr = sr[0]; ret_next = 16'h2000;
    ret_pc = jmp != 0 ? 16'h3ffe : 16'h2000;
    cp_dr_scan = scan_same;
    step();
    idle();
  endtask

  initial begin
    idle();
    trc_mode = 2'b00; exc_busy = 1'b0; rst = 1'b1;
    step(); step();
    rst = 1'b0;
    chk("R1 reset output", trc_req, 1'b0);
    // R1: no stale scan after reset
    retire(1, 1, 1, 1, 1'b0);
    chk("R1 cpgen after reset", trc_req, 1'b0);
    step();

    // Sweep for R2 R3 R4 R5 R6: mode x kind x sr x jump x dr.
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 5; k++)
        for (int sr = 0; sr < 2; sr++)
          for (int j = 0; j < 2; j++)
            for (int d = 0; d < 2; d++) begin
              logic same;
              string tag;
              same = ((m + k + sr + j) % 2) == 1;
              if (d != 0 && !same) begin
                cp_dr_scan = 1'b1; step(); cp_dr_scan = 1'b0;
              end
              retire(m, k, sr, j, (d != 0) && same);
              tag = (m == 2) ? "R2" : (m != 1) ? "R3" : (k == 1) ? "R6" :
                    (sr != 0) ? "R4" : "R5";
              chk(tag, trc_req, model(m, k, sr, j, d));
              step();
              chk("R2 single pulse", trc_req, 1'b0);
            end

    // R7: scan consumed by an untraced retire
    cp_dr_scan = 1'b1; step(); cp_dr_scan = 1'b0;
    retire(1, 0, 0, 0, 1'b0);
    chk("R7 plain seq", trc_req, 1'b0);
    retire(1, 1, 0, 0, 1'b0);
    chk("R7 no carry", trc_req, 1'b0);
    step();

    // R8: busy holds the request
    exc_busy = 1'b1;
    retire(2, 0, 0, 0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      chk("R8 held", trc_req, 1'b0);
      step();
    end
    exc_busy = 1'b0;
    step();
    chk("R8 released", trc_req, 1'b1);
    step();
    chk("R8 one pulse", trc_req, 1'b0);

    // R9: merging while held
    exc_busy = 1'b1;
    retire(2, 3, 0, 0, 1'b0);
    retire(1, 0, 1, 0, 1'b0);
    chk("R9 held", trc_req, 1'b0);
    exc_busy = 1'b0;
    step();
    chk("R9 merged pulse", trc_req, 1'b1);
    step();
    chk("R9 no second", trc_req, 1'b0);
    step();
    chk("R9 still quiet", trc_req, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule